// File: doc/BRIEF.md
# Chained Programmable Logic Cell

This block is a short row of programmable logic elements, like the ones tiled across a reconfigurable fabric. Each element has four data inputs. Its function comes from two 3-input lookup halves that share the three low inputs. The element works in one of two modes:

- **Single-function mode.** The fourth input picks between the two halves, so the element realises any 4-input Boolean function.
- **Add mode.** The two half outputs become the operand bits of a full adder. The carry ripples from each element into the next, so a row of elements forms a ripple adder.

Each element has one D flip-flop. A per-element select bit decides whether the element's output is taken from that flip-flop or straight from the combinational result.

The function of every element is set by a serial shift chain. While the load enable is high, one bit enters the chain per clock. The flip-flops keep their contents during loading. A synchronous reset clears the flip-flops and leaves the loaded function alone.

Top module: `lc_chain`

## Requirements
- R1: Each element holds 19 setting bits: bits 7:0 are lookup half A, bits 15:8 are lookup half B, bit 16 selects add mode (1 = add), bit 17 selects the flip-flop output (1 = registered), and bit 18 is unused. While `load_en` is high, every clock edge shifts `load_bit` into bit 18 of element 0, moves every bit one place down, and passes bit 0 of element k into bit 18 of element k+1. A full load is therefore the settings of element N-1 first, then down to element 0, each element's bits sent LSB first.
- R2: In single-function mode, the combinational result is half B indexed by {d2,d1,d0} when d3 is 1, and half A indexed the same way when d3 is 0. If T = {halfB, halfA}, the result is T[{d3,d2,d1,d0}].
- R3: In add mode, the combinational result is a XOR b XOR carry-in, where a and b are the outputs of halves A and B.
- R4: Every element produces carry-out = (a AND b) OR (carry-in AND (a XOR b)). Element 0 takes `carry_in`; element k takes the carry-out of element k-1; `carry_out` is the carry-out of the last element.
- R5: When `load_en` and `rst` are low, the flip-flop captures the combinational result at each clock edge. A registered output therefore shows the result one clock after the inputs change.
- R6: While `load_en` is high, the flip-flops keep their value.
- R7: A clock edge with `rst` high clears every flip-flop and does not change the loaded settings.
- R8: With the output-select bit at 0, the output follows the combinational result in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the flip-flops, active high |
| load_en | input | 1 | Shift-chain enable for loading settings |
| load_bit | input | 1 | Serial settings bit, entering at element 0 |
| din | input | 4*N_CELLS | Four data inputs per element; element k uses bits 4k+3..4k, with d0 at the LSB |
| carry_in | input | 1 | Carry into element 0 |
| dout | output | N_CELLS | One output per element |
| carry_out | output | 1 | Carry out of the last element |

## Verification
The hardest behaviour to reach from the ports is the flip-flop hold during loading. While `load_en` is high, the elements' function keeps changing, so the outputs mean nothing.

The stimulus first captures known values into registered elements. It then reloads exactly the same settings while the data inputs change, and reads the outputs right after loading ends. Any capture during the load would show up as a changed value.

Reset keeping the settings is checked the same way: after reset, the registered outputs must be zero, and the elements must then compute with their earlier function, with no reload in between.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_LUT_IN   = 3;
  localparam int LC_LUT_BITS = 1 << LC_LUT_IN;
  localparam int LC_DIN_W    = LC_LUT_IN + 1;
  localparam int LC_CFG_W    = 2 * LC_LUT_BITS + 3;

  typedef struct packed {
    logic                   spare;
    logic                   reg_out;
    logic                   arith;
    logic [LC_LUT_BITS-1:0] tbl_b;
    logic [LC_LUT_BITS-1:0] tbl_a;
  } lc_cfg_t;

  function automatic logic lc_fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic lc_fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int N_IN = 3,
  localparam int N_BITS = 1 << N_IN
) (
  input  logic [N_BITS-1:0] tbl,
  input  logic [N_IN-1:0]   sel,
  output logic              y
);
  assign y = tbl[sel];
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic                cfg_sin,
  output logic                cfg_sout,
  input  logic [LC_DIN_W-1:0] din,
  input  logic                cin,
  output logic                cout,
  output logic                dout
);
  lc_cfg_t cfg_q;
  logic lut_a, lut_b, norm_res, sum_res, comb_res, ff_q;

  // serial settings chain, not touched by reset
  always_ff @(posedge clk) begin
    if (load_en) cfg_q <= {cfg_sin, cfg_q[LC_CFG_W-1:1]};
  end
  assign cfg_sout = cfg_q[0];

  lc_lut #(.N_IN(LC_LUT_IN)) u_half_a (
    .tbl(cfg_q.tbl_a), .sel(din[LC_LUT_IN-1:0]), .y(lut_a));
  lc_lut #(.N_IN(LC_LUT_IN)) u_half_b (
    .tbl(cfg_q.tbl_b), .sel(din[LC_LUT_IN-1:0]), .y(lut_b));

  // mux 1: merge halves on the top input
  assign norm_res = din[LC_DIN_W-1] ? lut_b : lut_a;
  assign sum_res  = lc_fa_sum(lut_a, lut_b, cin);
  assign cout     = lc_fa_carry(lut_a, lut_b, cin);
  // mux 2: mode
  assign comb_res = cfg_q.arith ? sum_res : norm_res;

  always_ff @(posedge clk) begin
    if (rst)           ff_q <= 1'b0;
    else if (!load_en) ff_q <= comb_res;
  end

  // mux 3: registered or direct
  assign dout = cfg_q.reg_out ? ff_q : comb_res;

  // R1
  cfg_shift_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (cfg_q[LC_CFG_W-2:0] == $past(cfg_q[LC_CFG_W-1:1])) &&
                (cfg_q[LC_CFG_W-1] == $past(cfg_sin)));
  // R7
  cfg_keep_chk: assert property (@(posedge clk) disable iff (load_en)
    !load_en |=> $stable(cfg_q));
  // R3
  add_bits_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.arith |-> ({cout, comb_res} == ({1'b0, lut_a} + {1'b0, lut_b} + {1'b0, cin})));
  // R5
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ff_q == $past(comb_res));
  // R6
  ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(ff_q));
  // R7
  ff_clear_chk: assert property (@(posedge clk) rst |=> (ff_q == 1'b0));
endmodule

// File: rtl/lc_chain.sv
module lc_chain
  import lc_pkg::*;
#(
  parameter int N_CELLS = 4,
  localparam int DIN_W = N_CELLS * LC_DIN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               load_bit,
  input  logic [DIN_W-1:0]   din,
  input  logic               carry_in,
  output logic [N_CELLS-1:0] dout,
  output logic               carry_out
);
  logic [N_CELLS:0] carry;
  logic [N_CELLS:0] cfg_link;

  assign carry[0]    = carry_in;
  assign cfg_link[0] = load_bit;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    lc_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .cfg_sin  (cfg_link[k]),
      .cfg_sout (cfg_link[k+1]),
      .din      (din[k*LC_DIN_W +: LC_DIN_W]),
      .cin      (carry[k]),
      .cout     (carry[k+1]),
      .dout     (dout[k])
    );
  end

  assign carry_out = carry[N_CELLS];

  logic unused_tail;
  assign unused_tail = cfg_link[N_CELLS];
endmodule

// File: tb/tb_lc_chain.sv
module tb_lc_chain;
  localparam int N = 4;
  localparam int CW = 19;

  logic clk = 0, rst = 1, load_en = 0, load_bit = 0, carry_in = 0;
  logic [4*N-1:0] din = '0;
  logic [N-1:0] dout;
  logic carry_out;
  int total = 0, bad = 0;
  logic [CW-1:0] cfg [N];
  logic [15:0] tt [N];

  always #5 clk = ~clk;

  lc_chain #(.N_CELLS(N)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_bit(load_bit),
    .din(din), .carry_in(carry_in), .dout(dout), .carry_out(carry_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int k = N - 1; k >= 0; k--)
      for (int b = 0; b < CW; b++) begin
        @(negedge clk);
        load_en = 1; load_bit = cfg[k][b];
      end
    @(negedge clk);
    load_en = 0;
  endtask

  // cell settings from a 16-entry truth table
  function automatic logic [CW-1:0] mk(input logic [15:0] t, input logic arith, input logic regd);
    return {1'b0, regd, arith, t[15:8], t[7:0]};
  endfunction

  function automatic logic [N-1:0] expect_norm(input logic [4*N-1:0] d);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = tt[k][d[k*4 +: 4]];
    return r;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(negedge clk);

    // R2 R8: random 4-input tables, all 16 combinations per cell, direct outputs
    for (int round = 0; round < 4; round++) begin
      for (int k = 0; k < N; k++) begin
        tt[k] = 16'($urandom);
        cfg[k] = mk(tt[k], 1'b0, 1'b0);
      end
      load_all();
      rst = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        for (int k = 0; k < N; k++) din[k*4 +: 4] = 4'(i ^ k);
        #1;
        check("R2 R8 table lookup", 32'(dout), 32'(expect_norm(din)));
      end
    end

    // R1 R3 R4: ripple adder, half A passes d0, half B passes d1
    for (int k = 0; k < N; k++) cfg[k] = mk(16'hCCAA, 1'b1, 1'b0);
    load_all();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          logic [4:0] s;
          @(negedge clk);
          for (int k = 0; k < N; k++) din[k*4 +: 4] = {2'b00, y[k], x[k]};
          carry_in = c[0];
          s = 5'(x) + 5'(y) + 5'(c);
          #1;
          check("R1 R3 R4 ripple sum", 32'({carry_out, dout}), 32'(s));
        end
    carry_in = 0;

    // R5 R8: cells 2,3 registered, cells 0,1 direct
    for (int k = 0; k < N; k++) begin
      tt[k] = 16'($urandom) ^ 16'h5A3C;
      cfg[k] = mk(tt[k], 1'b0, k >= 2);
    end
    load_all();
    @(negedge clk);
    din = 16'h0000;
    @(negedge clk);
    prev = expect_norm(din);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      din = 16'($urandom);
      #1;
      check("R8 direct cells same cycle", 32'(dout[1:0]), 32'(expect_norm(din) & 4'b0011));
      check("R5 registered cells before edge", 32'(dout[3:2]), 32'(prev[3:2]));
      @(posedge clk); #1;
      check("R5 registered cells one clock later", 32'(dout[3:2]), 32'(expect_norm(din) >> 2));
      prev = expect_norm(din);
    end

    // R6: reload identical settings while inputs change; flip-flops must hold
    for (int k = 0; k < N; k++) cfg[k] = mk(tt[k], 1'b0, 1'b1);
    load_all();
    @(negedge clk);
    din = 16'h1234;
    @(negedge clk);
    prev = expect_norm(din);
    fork
      load_all();
      begin
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          din = 16'($urandom);
        end
      end
    join
    #1;
    check("R6 hold across load", 32'(dout), 32'(prev));
    @(posedge clk); #1;
    check("R6 capture resumes after load", 32'(dout), 32'(expect_norm(din)));

    // R7: reset clears flip-flops, settings survive
    @(negedge clk);
    din = 16'hFFFF;
    for (int k = 0; k < N; k++) din[k*4 +: 4] = 4'(k + 7);
    @(negedge clk);
    rst = 1;
    @(posedge clk); #1;
    check("R7 reset clears registers", 32'(dout), 32'h0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    check("R7 settings kept after reset", 32'(dout), 32'(expect_norm(din)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule